// File: doc/BRIEF.md
# Serial Display-RAM Write Sequencer

This block sits behind a serial slave front end that has already matched the device address and framed each transfer with start and stop strobes. It takes the resulting byte stream and turns it into single-cycle write commands for a display memory of 16 rows by 32 columns. Every byte is sorted into a row address, a column address or a data byte, and only data bytes cause a write.

The sender can give a full address for each data byte. It can give the row once and then column/data pairs. It can also give one starting address and then a run of data bytes, with the address stepping forward by itself. Bit 7 of an address byte separates rows from columns. Bit 6 of a column byte starts the self-stepping run, which then lasts until the next start or stop strobe. Each write also carries a flag that tells whether it lands in the control part of the memory, so that a neighbouring register decoder can pick those writes out.

Top module: `osd_ram_wr_seq`

## Requirements
- R1: When the sequencer is expecting an address, a byte with bit 7 = 1 loads the row from bits 3:0 and causes no write.
- R2: When the sequencer is expecting an address, a byte with bit 7 = 0 loads the column from bits 4:0 and causes no write. If bit 6 = 0, exactly the next byte is data, and the sequencer then expects an address again, either a row byte or a column byte. The sender may therefore switch freely between a full address per write and a row followed by column/data pairs.
- R3: A data byte produces exactly one write. wr_en is high for one clock, in the cycle after the clock edge that samples byte_vld, and it carries the current row, the current column and the byte.
- R4: A column byte with bit 6 = 1 enters burst mode. Every later byte is data, and the column steps up by one after each write.
- R5: In burst mode, a write at column 31 moves the address to column 0 of the next row, and a write at row 15, column 31 moves it to row 0, column 0.
- R6: Burst mode cannot be left by any byte value. A byte with bit 7 = 1 is written as data.
- R7: A start or stop strobe returns the sequencer to expecting an address and leaves burst mode. When a strobe and byte_vld are high in the same cycle, the byte is discarded.
- R8: After reset, a start or a stop, a data byte that arrives before any row byte causes no write.
- R9: wr_ctl is high with a write whose target is row 15 at columns 0 to 12, or rows 0 to 14 at columns 30 or 31. It is low for every other target.
- R10: After reset, wr_en is low and the sequencer expects an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_start | input | 1 | One-cycle strobe marking the start of a transfer |
| frm_stop | input | 1 | One-cycle strobe marking the end of a transfer |
| byte_vld | input | 1 | byte_dat holds a received byte this cycle |
| byte_dat | input | 8 | Received byte |
| wr_en | output | 1 | Write command to the display memory |
| wr_row | output | 4 | Row of the write |
| wr_col | output | 5 | Column of the write |
| wr_dat | output | 8 | Data of the write |
| wr_ctl | output | 1 | The write targets a control location |

## Verification
On every cycle the assertions check four things: burst mode stays set until a strobe, a strobe always returns the sequencer to expecting an address and clears the row-known flag, each burst write steps the column or wraps the row, and no write appears without a byte that was accepted one cycle earlier. What the bench's scenarios alone can show is that the right bytes are taken as rows, columns or data, that writes land at the right row and column across the mixed formats and the wrap points, that the control flag is correct, and that an orphan data byte or a byte that collides with a strobe is dropped.

// File: rtl/osd_seq_pkg.sv
// Shared types for the display-RAM write sequencer.
package osd_seq_pkg;
    // What the next accepted byte is taken to be.
    typedef enum logic [1:0] {
        CTX_ADDR  = 2'd0,   // row or column address
        CTX_DATA  = 2'd1,   // single data byte after a column
        CTX_BURST = 2'd2    // every byte is data, address self-steps
    } seq_ctx_e;
endpackage

// File: rtl/osd_seq_ctx.sv
// Byte classifier and context tracker.
// Decides for each accepted byte whether it is a row, a column or data,
// and keeps the context for the next byte. Assumes flush (start or stop)
// takes priority over a byte in the same cycle.
module osd_seq_ctx
    import osd_seq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_dat,
    output logic              ld_row,
    output logic              ld_col,
    output logic              data_hit,
    output logic              burst_on
);
    localparam int ROW_BIT   = BYTE_W - 1;
    localparam int BURST_BIT = BYTE_W - 2;

    seq_ctx_e ctx_q, ctx_d;
    logic     take;

    // Classify the current byte from context and flag bits.
    always_comb begin
        take     = byte_vld && !flush;
        ld_row   = take && (ctx_q == CTX_ADDR) &&  byte_dat[ROW_BIT];
        ld_col   = take && (ctx_q == CTX_ADDR) && !byte_dat[ROW_BIT];
        data_hit = take && (ctx_q != CTX_ADDR);
        burst_on = (ctx_q == CTX_BURST);
    end

    // Next context.
    always_comb begin
        ctx_d = ctx_q;
        if (flush) begin
            ctx_d = CTX_ADDR;
        end else if (take) begin
            unique case (ctx_q)
                CTX_ADDR: begin
                    if (!byte_dat[ROW_BIT])
                        ctx_d = byte_dat[BURST_BIT] ? CTX_BURST : CTX_DATA;
                end
                CTX_DATA:  ctx_d = CTX_ADDR;
                CTX_BURST: ctx_d = CTX_BURST;
                default:   ctx_d = CTX_ADDR;
            endcase
        end
    end

    // Context register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= CTX_ADDR;
        else        ctx_q <= ctx_d;
    end

    AST_BURST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q == CTX_BURST) && !flush |=> (ctx_q == CTX_BURST)); // R6
    AST_FLUSH_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ctx_q == CTX_ADDR)); // R7
endmodule

// File: rtl/osd_seq_addr.sv
// Row and column address holder.
// Loads the row and the column from address bytes, steps the address after
// each burst write with wrap, and tracks whether a row has been given since
// the last flush. Assumes that a load and a step never coincide.
module osd_seq_addr #(
    parameter int ROWS   = 16,
    parameter int COLS   = 32,
    parameter int BYTE_W = 8,
    parameter int ROW_W  = $clog2(ROWS),
    parameter int COL_W  = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              ld_row,
    input  logic              ld_col,
    input  logic              data_hit,
    input  logic              burst_on,
    input  logic [BYTE_W-1:0] byte_dat,
    output logic [ROW_W-1:0]  row_q,
    output logic [COL_W-1:0]  col_q,
    output logic              row_ok
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    logic adv;

    // A burst write moves the address forward once a row is known.
    always_comb adv = data_hit && burst_on && row_ok;

    // Row register with burst wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_q <= '0;
        else if (ld_row)
            row_q <= byte_dat[ROW_W-1:0];
        else if (adv && col_q == LAST_COL)
            row_q <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
    end

    // Column register with burst wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            col_q <= '0;
        else if (ld_col)
            col_q <= byte_dat[COL_W-1:0];
        else if (adv)
            col_q <= (col_q == LAST_COL) ? '0 : col_q + 1'b1;
    end

    // Row-known flag, cleared by every flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) row_ok <= 1'b0;
        else if (ld_row)     row_ok <= 1'b1;
    end

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv && (col_q != LAST_COL) |=>
            (col_q == $past(col_q) + 1'b1) && (row_q == $past(row_q))); // R4
    AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        adv && (col_q == LAST_COL) && (row_q == LAST_ROW) |=>
            (col_q == '0) && (row_q == '0)); // R5
    AST_ROW_FORGOTTEN: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !row_ok); // R8
endmodule

// File: rtl/osd_ram_wr_seq.sv
// Display-RAM write sequencer top.
// Converts a framed byte stream into one-cycle write commands and marks
// writes aimed at control locations. Assumes the byte source and the
// strobes are synchronous to clk and already address-matched.
module osd_ram_wr_seq #(
    parameter int ROWS        = 16,
    parameter int COLS        = 32,
    parameter int CTRL_COLS   = 13,
    parameter int ROWCTL_COLS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frm_start,
    input  logic                    frm_stop,
    input  logic                    byte_vld,
    input  logic [7:0]              byte_dat,
    output logic                    wr_en,
    output logic [$clog2(ROWS)-1:0] wr_row,
    output logic [$clog2(COLS)-1:0] wr_col,
    output logic [7:0]              wr_dat,
    output logic                    wr_ctl
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);
    localparam logic [ROW_W-1:0] CTRL_ROW  = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] CTRL_LIM  = COL_W'(CTRL_COLS);
    localparam logic [COL_W-1:0] ROWCTL_LO = COL_W'(COLS - ROWCTL_COLS);

    logic             flush, ld_row, ld_col, data_hit, burst_on, row_ok;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             tgt_ctl;

    // Either strobe restarts the sequencer.
    always_comb flush = frm_start || frm_stop;

    osd_seq_ctx #(.BYTE_W(8)) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .byte_vld (byte_vld),
        .byte_dat (byte_dat),
        .ld_row   (ld_row),
        .ld_col   (ld_col),
        .data_hit (data_hit),
        .burst_on (burst_on)
    );

    osd_seq_addr #(.ROWS(ROWS), .COLS(COLS), .BYTE_W(8),
                   .ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .ld_row   (ld_row),
        .ld_col   (ld_col),
        .data_hit (data_hit),
        .burst_on (burst_on),
        .byte_dat (byte_dat),
        .row_q    (row_q),
        .col_q    (col_q),
        .row_ok   (row_ok)
    );

    // Control-space decode of the current target.
    always_comb begin
        if (row_q == CTRL_ROW) tgt_ctl = (col_q < CTRL_LIM);
        else                   tgt_ctl = (col_q >= ROWCTL_LO);
    end

    // Registered write command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en  <= 1'b0;
            wr_row <= '0;
            wr_col <= '0;
            wr_dat <= '0;
            wr_ctl <= 1'b0;
        end else begin
            wr_en <= data_hit && row_ok;
            if (data_hit && row_ok) begin
                wr_row <= row_q;
                wr_col <= col_q;
                wr_dat <= byte_dat;
                wr_ctl <= tgt_ctl;
            end
        end
    end

    AST_WR_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(byte_vld) && !$past(frm_start || frm_stop)); // R3
    AST_NO_WR_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ld_row || ld_col |=> !wr_en); // R1
endmodule

// File: tb/osd_ram_wr_seq_bench.sv
`timescale 1ns/100ps
module osd_ram_wr_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_start = 1'b0, frm_stop = 1'b0, byte_vld = 1'b0;
    logic [7:0] byte_dat = '0;
    logic       wr_en, wr_ctl;
    logic [3:0] wr_row;
    logic [4:0] wr_col;
    logic [7:0] wr_dat;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // Observed write after the last byte.
    logic       o_en, o_ctl;
    logic [3:0] o_row;
    logic [4:0] o_col;
    logic [7:0] o_dat;

    always #2.5 clk = ~clk;

    osd_ram_wr_seq u_osd_ram_wr_seq (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_stop(frm_stop),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .wr_en(wr_en),
        .wr_row(wr_row), .wr_col(wr_col), .wr_dat(wr_dat), .wr_ctl(wr_ctl)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic capture();
        o_en = wr_en; o_row = wr_row; o_col = wr_col; o_dat = wr_dat; o_ctl = wr_ctl;
    endtask

    // Send one byte; outputs are captured one cycle later.
    task automatic put(input logic [7:0] b);
        @(negedge clk); byte_vld = 1'b1; byte_dat = b;
        @(negedge clk); byte_vld = 1'b0; capture();
    endtask

    task automatic strobe(input bit is_stop);
        @(negedge clk); if (is_stop) frm_stop = 1'b1; else frm_start = 1'b1;
        @(negedge clk); frm_stop = 1'b0; frm_start = 1'b0; capture();
    endtask

    task automatic exp_wr(input string tag, input logic [3:0] r, input logic [4:0] c,
                          input logic [7:0] d, input logic k);
        check(tag, {13'd0, o_en, o_row, o_col, o_dat, o_ctl}, {13'd0, 1'b1, r, c, d, k});
    endtask

    task automatic exp_none(input string tag);
        check(tag, {31'd0, o_en}, 32'd0);
    endtask

    task automatic t_reset();
        capture();
        exp_none("R10 reset wr_en low");
        // Address context after reset: row then column then data.
        put(8'h81); exp_none("R10 R1 row byte after reset");
        put(8'h02); exp_none("R10 R2 column byte");
        put(8'h5A); exp_wr("R10 R3 first write", 4'd1, 5'd2, 8'h5A, 1'b0);
    endtask

    task automatic t_formats();
        strobe(0);
        put(8'h82); exp_none("R1 row 2");
        put(8'h07); exp_none("R2 col 7");
        put(8'h11); exp_wr("R3 format a write", 4'd2, 5'd7, 8'h11, 1'b0);
        put(8'h09); exp_none("R2 col after data");
        put(8'h22); exp_wr("R2 format b write", 4'd2, 5'd9, 8'h22, 1'b0);
        put(8'h8F); exp_none("R1 row 15 back to format a");
        put(8'h0C); put(8'h33);
        exp_wr("R9 row15 col12 is control", 4'd15, 5'd12, 8'h33, 1'b1);
        put(8'h0D); put(8'h44);
        exp_wr("R9 row15 col13 not control", 4'd15, 5'd13, 8'h44, 1'b0);
        put(8'h84); put(8'h00); put(8'hC3);
        exp_wr("R3 data with bit7 set in data context", 4'd4, 5'd0, 8'hC3, 1'b0);
        strobe(1);
        exp_none("R7 stop makes no write");
    endtask

    task automatic t_burst();
        strobe(0);
        put(8'h83); put(8'h5E); exp_none("R4 burst column byte");
        put(8'hA1); exp_wr("R4 R9 burst col30", 4'd3, 5'd30, 8'hA1, 1'b1);
        put(8'hA2); exp_wr("R4 R9 burst col31", 4'd3, 5'd31, 8'hA2, 1'b1);
        put(8'h85); exp_wr("R5 R6 col wrap next row, row-like byte is data", 4'd4, 5'd0, 8'h85, 1'b0);
        put(8'h1F); exp_wr("R6 column-like byte is data", 4'd4, 5'd1, 8'h1F, 1'b0);
    endtask

    task automatic t_wrap();
        strobe(0);
        put(8'h8F); put(8'h5F);
        put(8'h01); exp_wr("R5 R9 row15 col31", 4'd15, 5'd31, 8'h01, 1'b0);
        put(8'h02); exp_wr("R5 wrap to row0 col0", 4'd0, 5'd0, 8'h02, 1'b0);
        put(8'h03); exp_wr("R4 step after wrap", 4'd0, 5'd1, 8'h03, 1'b0);
    endtask

    task automatic t_flush();
        // Burst active, then stop: next byte is a row again.
        strobe(0); put(8'h80); put(8'h40); put(8'h10);
        strobe(1);
        put(8'h85); exp_none("R7 row after stop");
        put(8'h01); exp_none("R7 column after stop");
        put(8'h66); exp_wr("R7 addressed write after stop", 4'd5, 5'd1, 8'h66, 1'b0);
        // Byte colliding with start is discarded.
        @(negedge clk); frm_start = 1'b1; byte_vld = 1'b1; byte_dat = 8'h83;
        @(negedge clk); frm_start = 1'b0; byte_vld = 1'b0; capture();
        exp_none("R7 collision no write");
        put(8'h01); exp_none("R7 column after collision");
        put(8'h99); exp_none("R7 R8 collided row byte was discarded");
    endtask

    task automatic t_no_row();
        strobe(0);
        put(8'h04); put(8'h12); exp_none("R8 data without row dropped");
        put(8'h44); put(8'h13); exp_none("R8 burst data without row dropped");
        strobe(0);
        put(8'h81); put(8'h1E); put(8'h14);
        exp_wr("R9 row1 col30 control", 4'd1, 5'd30, 8'h14, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_formats();
        t_burst();
        t_wrap();
        t_flush();
        t_no_row();
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule